// File: doc/BRIEF.md
# Dual-Slope Timer Period Calculator

This unit turns a requested timer period, given in microseconds, into the two settings a dual-slope (up then down) 16-bit timer needs: a clock-divider select code and a TOP value. The input clock frequency is a build-time parameter that must be a whole multiple of 2 MHz. The base cycle count is that frequency divided by 2 MHz, multiplied by the period. The division by two accounts for the counter running up to TOP and back down in each period.

The unit tries five dividers in order: 1, 8, 64, 256 and 1024. It uses the first one for which the scaled count fits in 16 bits. If none fits, it saturates to the largest setting.

A request is taken through a valid/ready handshake. The input side raises `in_ready` whenever the unit is out of reset, so it accepts one request per cycle with no back-pressure. The result side has no ready signal. Each accepted request yields a one-cycle `res_valid` pulse in the following cycle, and the consumer must capture the result in that cycle. Between pulses the result outputs hold their last value.

Top module: `period_prescale_calc`

## Requirements
- R1: The base count equals the requested period multiplied by CLK_HZ/2,000,000, computed without truncation for any 32-bit period.
- R2: When the base count is below 65536, the result is select code 1 (divide by 1) with TOP equal to the base count.
- R3: Otherwise, when base count / 8 is below 65536, the result is select code 2 with TOP = base count / 8 (truncated).
- R4: Otherwise, when base count / 64 is below 65536, the result is select code 3 with TOP = base count / 64.
- R5: Otherwise, when base count / 256 or, failing that, base count / 1024 is below 65536, the result is select code 4 or code 5 respectively, with that quotient as TOP.
- R6: When even base count / 1024 is 65536 or more, the result saturates to select code 5 with TOP = 65535.
- R7: A zero period gives TOP = 0, select code 1 and `res_zero` = 1. Every nonzero period gives `res_zero` = 0.
- R8: `res_valid` is high for exactly the cycle after each cycle in which `in_valid` and `in_ready` are both high, and it is low in every other cycle. Back-to-back requests give back-to-back results.
- R9: `in_ready` is high in every cycle after reset is released. While `res_valid` is low, `res_sel`, `res_top` and `res_zero` keep their previous values.
- R10: During and right after a synchronous active-low reset, `res_valid`, `res_sel`, `res_top`, `res_zero` and `in_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_period_us | input | 32 | Requested period in microseconds |
| res_valid | output | 1 | One-cycle result strobe |
| res_sel | output | 3 | Divider select code (1 = /1, 2 = /8, 3 = /64, 4 = /256, 5 = /1024) |
| res_top | output | 16 | TOP value for the timer |
| res_zero | output | 1 | Request was a zero period |

## Verification
A wrong fit decision in one divider stage shows up at the ports in the cycle after the request. It appears either as a select code one step off or as a TOP value that is wrong by a factor of 4 or 8. Most such errors sit at the exact period where a scaled count crosses 65536, so every boundary is driven at, just below and just above its crossing. A broken strobe or hold path shows up within two cycles, as a missing or extra `res_valid` pulse or as result outputs that change while the strobe is low.

// File: rtl/pscl_pkg.sv
package pscl_pkg;
  localparam int NUM_DIV = 5;

  // cumulative right shift applied before stage i is checked
  function automatic int stage_shift(input int i);
    if (i == 0) return 0;
    else if (i <= 2) return 3 * i;
    else return 6 + 2 * (i - 2);
  endfunction

  // divider select code of stage i
  function automatic int stage_code(input int i);
    return i + 1;
  endfunction
endpackage

// File: rtl/pscl_stage.sv
module pscl_stage #(
  parameter int PROD_W = 36,
  parameter int TOP_W  = 16,
  parameter int SHIFT  = 0
) (
  input  logic [PROD_W-1:0] count,
  output logic              fit,
  output logic [TOP_W-1:0]  top
);
  logic [PROD_W-1:0] scaled;

  always_comb begin
    scaled = count >> SHIFT;
    fit    = (scaled >> TOP_W) == '0;
    top    = scaled[TOP_W-1:0];
  end
endmodule

// File: rtl/pscl_select.sv
module pscl_select #(
  parameter int N     = 5,
  parameter int TOP_W = 16,
  parameter int SEL_W = 3
) (
  input  logic [N-1:0]            fit,
  input  logic [N-1:0][TOP_W-1:0] tops,
  output logic [SEL_W-1:0]        sel,
  output logic [TOP_W-1:0]        top
);
  always_comb begin
    sel = SEL_W'(pscl_pkg::stage_code(N - 1));
    top = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (fit[i]) begin
        sel = SEL_W'(pscl_pkg::stage_code(i));
        top = tops[i];
      end
    end
  end

  // a larger shift must fit whenever a smaller one does (R5)
  generate
    for (genvar g = 0; g < N - 1; g++) begin : g_mono
      always_comb begin
        assert_fit_monotone_R5: assert (!fit[g] || fit[g+1]);
      end
    end
  endgenerate
endmodule

// File: rtl/period_prescale_calc.sv
module period_prescale_calc #(
  parameter int CLK_HZ   = 16_000_000,
  parameter int PERIOD_W = 32,
  parameter int TOP_W    = 16,
  parameter int SEL_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [PERIOD_W-1:0] in_period_us,
  output logic                res_valid,
  output logic [SEL_W-1:0]    res_sel,
  output logic [TOP_W-1:0]    res_top,
  output logic                res_zero
);
  localparam int N       = pscl_pkg::NUM_DIV;
  localparam int SCALE   = CLK_HZ / 2_000_000;
  localparam int SCALE_W = $clog2(SCALE + 1);
  localparam int PROD_W  = PERIOD_W + SCALE_W;
  localparam logic [PROD_W-1:0] SCALE_V = PROD_W'(SCALE);

  logic [PROD_W-1:0]         count;
  logic [N-1:0]              fit;
  logic [N-1:0][TOP_W-1:0]   tops;
  logic [SEL_W-1:0]          pick_sel;
  logic [TOP_W-1:0]          pick_top;
  logic                      accept;
  logic                      ready_q;

  assign count  = PROD_W'(in_period_us) * SCALE_V;
  assign accept = in_valid && ready_q;
  assign in_ready = ready_q;

  generate
    for (genvar g = 0; g < N; g++) begin : g_stage
      pscl_stage #(
        .PROD_W(PROD_W),
        .TOP_W (TOP_W),
        .SHIFT (pscl_pkg::stage_shift(g))
      ) i_stage (
        .count(count),
        .fit  (fit[g]),
        .top  (tops[g])
      );
    end
  endgenerate

  pscl_select #(.N(N), .TOP_W(TOP_W), .SEL_W(SEL_W)) i_select (
    .fit (fit),
    .tops(tops),
    .sel (pick_sel),
    .top (pick_top)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      res_valid <= 1'b0;
      res_sel   <= '0;
      res_top   <= '0;
      res_zero  <= 1'b0;
    end else begin
      ready_q   <= 1'b1;
      res_valid <= accept;
      if (accept) begin
        res_sel  <= pick_sel;
        res_top  <= pick_top;
        res_zero <= (in_period_us == '0);
      end
    end
  end

  assert_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> res_valid);
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !res_valid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_sel) && $stable(res_top) && $stable(res_zero)));
  assert_code_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_sel >= SEL_W'(1) && res_sel <= SEL_W'(N)));
  assert_zero_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_zero) |-> (res_top == '0 && res_sel == SEL_W'(1)));
  assert_ready_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);
endmodule

// File: tb/test_period_prescale_calc.sv
`timescale 1ns/1ps
module test_period_prescale_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_period_us = '0;
  logic        res_valid;
  logic [2:0]  res_sel;
  logic [15:0] res_top;
  logic        res_zero;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  period_prescale_calc #(.CLK_HZ(16_000_000)) i_period_prescale_calc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_period_us(in_period_us), .res_valid(res_valid), .res_sel(res_sel),
    .res_top(res_top), .res_zero(res_zero)
  );

  // reference: divide by 1,8,64,256,1024 in turn (R1..R6)
  function automatic void model(input longint unsigned p, output int sel,
                                output int top);
    longint unsigned cnt = p * 64'd8;
    longint unsigned divs [5] = '{1, 8, 64, 256, 1024};
    sel = 5; top = 65535;
    for (int i = 4; i >= 0; i--) begin
      if (cnt / divs[i] < 65536) begin
        sel = i + 1;
        top = int'(cnt / divs[i]);
      end
    end
  endfunction

  function automatic string req_of(input int sel, input bit sat);
    if (sat) return "R6";
    case (sel)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check_result(input longint unsigned p);
    int es, et;
    bit sat;
    model(p, es, et);
    sat = (p * 64'd8 / 1024) >= 65536;
    vectors++;
    if (!res_valid) begin
      fails++; $display("FAIL R8 p=%0d res_valid=%0d expected 1", p, res_valid);
    end
    if (res_sel != 3'(es) || res_top != 16'(et)) begin
      fails++;
      $display("FAIL %s/R1 p=%0d sel=%0d top=%0d expected sel=%0d top=%0d",
               req_of(es, sat), p, res_sel, res_top, es, et);
    end
    if (res_zero != (p == 0)) begin
      fails++; $display("FAIL R7 p=%0d zero=%0d expected %0d", p, res_zero, p == 0);
    end
  endtask

  // single request followed by an idle cycle that checks strobe and hold
  task automatic apply(input longint unsigned p);
    logic [2:0] s; logic [15:0] t; logic z;
    @(negedge clk);
    in_valid = 1'b1; in_period_us = 32'(p);
    @(negedge clk);
    in_valid = 1'b0; in_period_us = 32'hA5A5_A5A5;
    check_result(p);
    s = res_sel; t = res_top; z = res_zero;
    @(negedge clk);
    vectors++;
    if (res_valid || res_sel != s || res_top != t || res_zero != z) begin
      fails++;
      $display("FAIL R8/R9 idle valid=%0d sel=%0d top=%0d expected valid=0 sel=%0d top=%0d",
               res_valid, res_sel, res_top, s, t);
    end
    if (!in_ready) begin
      fails++; $display("FAIL R9 in_ready=%0d expected 1", in_ready);
    end
  endtask

  initial begin
    longint unsigned bnd [6] = '{8192, 65536, 524288, 2097152, 8388608, 0};
    longint unsigned lcg = 64'd12345;
    repeat (3) @(negedge clk);
    // R10 reset state
    vectors++;
    if (res_valid || res_sel != 0 || res_top != 0 || res_zero || in_ready) begin
      fails++;
      $display("FAIL R10 valid=%0d sel=%0d top=%0d zero=%0d ready=%0d expected all 0",
               res_valid, res_sel, res_top, res_zero, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R7 zero, then a low sweep
    for (int p = 0; p < 300; p++) apply(longint'(p));
    // divider boundaries R2..R6
    for (int b = 0; b < 5; b++)
      for (int d = -3; d <= 3; d++) apply(bnd[b] + longint'(d));
    apply(64'hFFFF_FFFF);
    apply(64'h8000_0000);
    // spread across magnitudes
    for (int k = 0; k < 1500; k++) begin
      lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
      apply((lcg >> 32) >> (lcg[4:0] % 32));
    end
    // R8 back-to-back requests
    @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      in_valid = 1'b1; in_period_us = 32'(k * 4099);
      @(negedge clk);
      check_result(longint'(k * 4099));
    end
    in_valid = 1'b0;
    @(negedge clk);
    vectors++;
    if (res_valid) begin
      fails++; $display("FAIL R8 res_valid=%0d expected 0", res_valid);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule